// File: doc/BRIEF.md
# Fast-Gradient Box-Projected Update Engine

This block carries out the element-wise part of a fast-gradient solver whose variables are held inside per-element bounds. It keeps local vectors for the original signal, the lower and upper bounds, the current gradient, the momentum point and the previous iterate. A per-iteration momentum table and a scalar step factor complete its inputs. After a start pulse it runs an initialisation sweep and then a fixed number of iterations. Each iteration streams one element per cycle through a seven-stage pipeline. For every element the pipeline applies the gradient step, clamps the result to the element's box, extrapolates with momentum and forms the residual against the original signal.

The residual stream feeds an external spectral stage, which is outside this block. After each pass the engine requests the new gradient and takes it as a stream of words. Only once that stream is complete does the new iterate and momentum point replace the old one. After the last iteration the final iterate is streamed out. A host fills the vectors and the momentum table through a small write port while the engine is idle.

Top module: `fg_update_engine`

## Requirements
- R1: Every value is 12-bit two's complement with 8 fraction bits (range -2048..2047 codes). A product is formed at 24 bits and shifted right arithmetically by 8, which rounds toward negative infinity. Every product, sum and difference is then clamped to -2048..2047 instead of wrapping.
- R2: A start pulse sampled while idle begins an initialisation sweep of N cycles. The sweep sets every gradient word to 0 and sets both the momentum point and the previous iterate to the original signal.
- R3: For element i the unconstrained value is t = sat(c[i] - sat(floor(g[i]*L/256))), where L is the `lipschitz` input.
- R4: The new iterate is checked against the upper bound first. It is the upper bound when t exceeds it, otherwise the lower bound when t is below that, otherwise t. This order decides the result when lower > upper.
- R5: The new momentum point is c' = sat(yn + sat(floor(d[k]*sat(yn - y[i])/256))). Here d[k] is the momentum table entry for the current iteration k, counted from 0.
- R6: The residual sat(c' - x[i]) appears on `res_data`, one element per cycle in index order 0..N-1, with `res_idx` giving the index.
- R7: `grad_load_req` rises in the cycle after the last residual of a pass. It stays high until N words have been accepted on cycles with `grad_valid` high, written to indices 0..N-1 in order; idle cycles between words are allowed. `grad_valid` is ignored when no request is pending. The new iterate and momentum point take effect only from the next pass, whose first residual appears 8 cycles after the cycle of the last accepted word.
- R8: After the load that ends the last iteration, the final iterate streams on `y_data`/`y_idx` for N consecutive cycles. The stream starts 2 cycles after the last accepted word and runs in index order. `done` is high with the last word only, and `busy` is low in the following cycle.
- R9: A write selects its vector by `cfg_sel`: 0 is the original signal, 1 the lower bounds, 2 the upper bounds and 3 the momentum table (indexed by `cfg_addr`). Writes and start pulses are ignored while `busy` is high.
- R10: A pass takes N+7 cycles. The first residual after a start pulse appears N+8 cycles after the cycle in which start was sampled.
- R11: After reset, `busy`, `res_valid`, `grad_load_req`, `y_valid` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a solve (idle only) |
| cfg_we | input | 1 | Vector/table write strobe |
| cfg_sel | input | 2 | Write target: 0 signal, 1 lower, 2 upper, 3 momentum |
| cfg_addr | input | $clog2(N) | Write index |
| cfg_data | input | 12 | Write value |
| lipschitz | input | 12 | Step factor, held during a solve |
| busy | output | 1 | Solve in progress |
| res_valid | output | 1 | Residual word valid |
| res_idx | output | $clog2(N) | Residual element index |
| res_data | output | 12 | Residual value |
| grad_load_req | output | 1 | Waiting for new gradient words |
| grad_valid | input | 1 | Gradient word strobe |
| grad_data | input | 12 | Gradient word |
| y_valid | output | 1 | Final iterate word valid |
| y_idx | output | $clog2(N) | Final iterate index |
| y_data | output | 12 | Final iterate value |
| done | output | 1 | Last word of the final iterate |

## Verification
A wrong bank selection or an early commit of the new iterate leaves the current pass intact. It corrupts the next pass instead, so it shows up as wrong residuals one full pass plus a gradient load later, at the latest in the final iterate stream. A misaligned pipeline stage, or a momentum entry read for the wrong iteration, corrupts residual values or indices from the first element of the affected pass. An off-by-one in the sequence counter moves the request edge, the first residual or the output stream by a cycle, and these cycle positions are measured directly against the start pulse and the last gradient word.

// File: rtl/fg_pkg.sv
package fg_pkg;

    localparam int W    = 12;
    localparam int FRAC = 8;
    localparam int PW   = 2 * W;
    localparam int PIPE = 7;

    typedef logic signed [W-1:0] fx_t;

    localparam fx_t FX_MAX = fx_t'((2 ** (W - 1)) - 1);
    localparam fx_t FX_MIN = fx_t'(-(2 ** (W - 1)));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_PASS,
        ST_GRAD,
        ST_OUT
    } seq_state_e;

    typedef struct packed {
        fx_t c;
        fx_t yold;
        fx_t x;
        fx_t lo;
        fx_t hi;
        fx_t dl;
    } elem_t;

    function automatic fx_t fx_sat(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] hi_lim;
        logic signed [PW-1:0] lo_lim;
        hi_lim = PW'(FX_MAX);
        lo_lim = PW'(FX_MIN);
        if (v > hi_lim)      return FX_MAX;
        else if (v < lo_lim) return FX_MIN;
        else                 return v[W-1:0];
    endfunction

    function automatic fx_t fx_add(input fx_t a, input fx_t b);
        logic signed [PW-1:0] s;
        s = PW'(a) + PW'(b);
        return fx_sat(s);
    endfunction

    function automatic fx_t fx_sub(input fx_t a, input fx_t b);
        logic signed [PW-1:0] s;
        s = PW'(a) - PW'(b);
        return fx_sat(s);
    endfunction

    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [PW-1:0] p;
        p = PW'(a) * PW'(b);
        return fx_sat(p >>> FRAC);
    endfunction

    function automatic fx_t fx_clamp(input fx_t v, input fx_t lo, input fx_t hi);
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/fg_vec_mem.sv
module fg_vec_mem
    import fg_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  fx_t           wdata,
    input  logic [AW-1:0] raddr,
    output fx_t           rdata
);

    fx_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fg_update_pipe.sv
module fg_update_pipe
    import fg_pkg::*;
#(
    parameter int IW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [IW-1:0] in_idx,
    input  fx_t           in_grad,
    input  elem_t         in_elem,
    input  fx_t           lip,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output fx_t           out_y,
    output fx_t           out_c,
    output fx_t           out_res
);

    logic [PIPE:1] vq;
    logic [IW-1:0] iq [1:PIPE];

    fx_t g1, c1, y1, x1, lo1, hi1, dl1;
    fx_t gl2, c2, y2, x2, lo2, hi2, dl2;
    fx_t yt3, y3, x3, lo3, hi3, dl3;
    fx_t yn4, y4, x4, dl4;
    fx_t dy5, yn5, x5, dl5;
    fx_t m6, yn6, x6;
    fx_t c_next;

    always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= {vq[PIPE-1:1], in_valid};
    end

    always_ff @(posedge clk) begin
        iq[1] <= in_idx;
        for (int j = 2; j <= PIPE; j++) iq[j] <= iq[j-1];
    end

    // stage 1: capture operands
    always_ff @(posedge clk) begin
        g1  <= in_grad;
        c1  <= in_elem.c;
        y1  <= in_elem.yold;
        x1  <= in_elem.x;
        lo1 <= in_elem.lo;
        hi1 <= in_elem.hi;
        dl1 <= in_elem.dl;
    end

    // stage 2: scaled gradient
    always_ff @(posedge clk) begin
        gl2 <= fx_mul(g1, lip);
        c2  <= c1;
        y2  <= y1;
        x2  <= x1;
        lo2 <= lo1;
        hi2 <= hi1;
        dl2 <= dl1;
    end

    // stage 3: unconstrained step
    always_ff @(posedge clk) begin
        yt3 <= fx_sub(c2, gl2);
        y3  <= y2;
        x3  <= x2;
        lo3 <= lo2;
        hi3 <= hi2;
        dl3 <= dl2;
    end

    // stage 4: box projection, upper bound tested first
    always_ff @(posedge clk) begin
        yn4 <= fx_clamp(yt3, lo3, hi3);
        y4  <= y3;
        x4  <= x3;
        dl4 <= dl3;
    end

    // stage 5: iterate difference
    always_ff @(posedge clk) begin
        dy5 <= fx_sub(yn4, y4);
        yn5 <= yn4;
        x5  <= x4;
        dl5 <= dl4;
    end

    // stage 6: momentum term
    always_ff @(posedge clk) begin
        m6  <= fx_mul(dl5, dy5);
        yn6 <= yn5;
        x6  <= x5;
    end

    // stage 7: extrapolated point and residual
    assign c_next = fx_add(yn6, m6);

    always_ff @(posedge clk) begin
        out_y   <= yn6;
        out_c   <= c_next;
        out_res <= fx_sub(c_next, x6);
    end

    assign out_valid = vq[PIPE];
    assign out_idx   = iq[PIPE];

    assert_box_R4: assert property (@(posedge clk) disable iff (rst)
        (vq[3] && (lo3 <= hi3)) |=> ((yn4 >= $past(lo3)) && (yn4 <= $past(hi3))));

    assert_upper_first_R4: assert property (@(posedge clk) disable iff (rst)
        (vq[3] && (yt3 > hi3)) |=> (yn4 == $past(hi3)));

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, PIPE));

    assert_idx_order_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_idx == $past(in_idx, PIPE)));

endmodule

// File: rtl/fg_sequencer.sv
module fg_sequencer
    import fg_pkg::*;
#(
    parameter int N     = 512,
    parameter int ITERS = 30,
    localparam int AW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + PIPE),
    localparam int KW = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          grad_valid,
    output logic          busy,
    output logic          init_we,
    output logic          issue_v,
    output logic          grad_we,
    output logic          grad_req,
    output logic          out_v,
    output logic          out_last,
    output logic [AW-1:0] seq_addr,
    output logic [KW-1:0] k_idx,
    output logic          cur_bank
);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic [KW-1:0] k;
    logic          bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            k    <= '0;
            bank <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_INIT;
                        cnt <= '0;
                        k   <= '0;
                    end
                end
                ST_INIT: begin
                    if (cnt == CW'(N - 1)) begin
                        st  <= ST_PASS;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PASS: begin
                    if (cnt == CW'(N + PIPE - 1)) begin
                        st  <= ST_GRAD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GRAD: begin
                    if (grad_valid) begin
                        if (cnt == CW'(N - 1)) begin
                            cnt  <= '0;
                            bank <= ~bank;
                            if (k == KW'(ITERS - 1)) begin
                                st <= ST_OUT;
                            end else begin
                                k  <= k + 1'b1;
                                st <= ST_PASS;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_OUT: begin
                    if (cnt == CW'(N - 1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign init_we  = (st == ST_INIT);
    assign issue_v  = (st == ST_PASS) && (cnt < CW'(N));
    assign grad_req = (st == ST_GRAD);
    assign grad_we  = grad_req && grad_valid;
    assign out_v    = (st == ST_OUT);
    assign out_last = out_v && (cnt == CW'(N - 1));
    assign seq_addr = cnt[AW-1:0];
    assign k_idx    = k;
    assign cur_bank = bank;

    assert_k_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (k < KW'(ITERS)));

    assert_bank_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (grad_we && (cnt == CW'(N - 1))) |=> (cur_bank != $past(cur_bank)));

endmodule

// File: rtl/fg_update_engine.sv
module fg_update_engine
    import fg_pkg::*;
#(
    parameter int N     = 512,
    parameter int ITERS = 30,
    localparam int AW = (N > 1) ? $clog2(N) : 1,
    localparam int KW = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_addr,
    input  fx_t           cfg_data,
    input  fx_t           lipschitz,
    output logic          busy,
    output logic          res_valid,
    output logic [AW-1:0] res_idx,
    output fx_t           res_data,
    output logic          grad_load_req,
    input  logic          grad_valid,
    input  fx_t           grad_data,
    output logic          y_valid,
    output logic [AW-1:0] y_idx,
    output fx_t           y_data,
    output logic          done
);

    logic          init_we, issue_v, grad_we, out_v, out_last, cur_bank;
    logic [AW-1:0] seq_addr;
    logic [KW-1:0] k_idx;

    fg_sequencer #(.N(N), .ITERS(ITERS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .grad_valid (grad_valid),
        .busy       (busy),
        .init_we    (init_we),
        .issue_v    (issue_v),
        .grad_we    (grad_we),
        .grad_req   (grad_load_req),
        .out_v      (out_v),
        .out_last   (out_last),
        .seq_addr   (seq_addr),
        .k_idx      (k_idx),
        .cur_bank   (cur_bank)
    );

    logic host_we;
    assign host_we = cfg_we && !busy;

    fx_t x_rd, lo_rd, hi_rd, dl_rd, g_rd;

    fg_vec_mem #(.DEPTH(N)) u_x (
        .clk(clk), .we(host_we && (cfg_sel == 2'd0)), .waddr(cfg_addr),
        .wdata(cfg_data), .raddr(seq_addr), .rdata(x_rd));

    fg_vec_mem #(.DEPTH(N)) u_lo (
        .clk(clk), .we(host_we && (cfg_sel == 2'd1)), .waddr(cfg_addr),
        .wdata(cfg_data), .raddr(seq_addr), .rdata(lo_rd));

    fg_vec_mem #(.DEPTH(N)) u_hi (
        .clk(clk), .we(host_we && (cfg_sel == 2'd2)), .waddr(cfg_addr),
        .wdata(cfg_data), .raddr(seq_addr), .rdata(hi_rd));

    fg_vec_mem #(.DEPTH(ITERS)) u_dl (
        .clk(clk), .we(host_we && (cfg_sel == 2'd3)), .waddr(cfg_addr[KW-1:0]),
        .wdata(cfg_data), .raddr(k_idx), .rdata(dl_rd));

    fg_vec_mem #(.DEPTH(N)) u_grad (
        .clk(clk), .we(init_we || grad_we), .waddr(seq_addr),
        .wdata(init_we ? fx_t'('0) : grad_data), .raddr(seq_addr), .rdata(g_rd));

    // Two banks each for iterate and momentum point: a pass reads the live
    // bank and writes the other; the bank flips when the gradient load ends.
    logic          wb_valid;
    logic [AW-1:0] wb_idx;
    fx_t           wb_y, wb_c;
    logic [AW-1:0] st_waddr;
    fx_t           st_wy, st_wc;
    fx_t           y_rd [2];
    fx_t           c_rd [2];
    fx_t           y_cur, c_cur;

    assign st_waddr = init_we ? seq_addr : wb_idx;
    assign st_wy    = init_we ? x_rd : wb_y;
    assign st_wc    = init_we ? x_rd : wb_c;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic bank_we;
        assign bank_we = (init_we && (cur_bank == 1'(b))) ||
                         (wb_valid && (cur_bank != 1'(b)));

        fg_vec_mem #(.DEPTH(N)) u_y (
            .clk(clk), .we(bank_we), .waddr(st_waddr),
            .wdata(st_wy), .raddr(seq_addr), .rdata(y_rd[b]));

        fg_vec_mem #(.DEPTH(N)) u_c (
            .clk(clk), .we(bank_we), .waddr(st_waddr),
            .wdata(st_wc), .raddr(seq_addr), .rdata(c_rd[b]));
    end

    assign y_cur = cur_bank ? y_rd[1] : y_rd[0];
    assign c_cur = cur_bank ? c_rd[1] : c_rd[0];

    elem_t in_elem;
    assign in_elem = '{c: c_cur, yold: y_cur, x: x_rd, lo: lo_rd, hi: hi_rd, dl: dl_rd};

    fg_update_pipe #(.IW(AW)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (issue_v),
        .in_idx    (seq_addr),
        .in_grad   (g_rd),
        .in_elem   (in_elem),
        .lip       (lipschitz),
        .out_valid (wb_valid),
        .out_idx   (wb_idx),
        .out_y     (wb_y),
        .out_c     (wb_c),
        .out_res   (res_data)
    );

    assign res_valid = wb_valid;
    assign res_idx   = wb_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            y_valid <= 1'b0;
            done    <= 1'b0;
        end else begin
            y_valid <= out_v;
            done    <= out_last;
        end
        y_idx  <= seq_addr;
        y_data <= y_cur;
    end

    assert_req_after_pass_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(grad_load_req) |-> $past(res_valid));

    assert_no_res_in_load_R7: assert property (@(posedge clk) disable iff (rst)
        grad_load_req |-> !res_valid);

    assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (y_valid && (y_idx == AW'(N - 1))));

    assert_y_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (!res_valid && !grad_load_req));

endmodule

// File: tb/test_fg_update_engine.sv
`timescale 1ns/1ps
module test_fg_update_engine;

    localparam int N  = 8;
    localparam int IT = 3;
    localparam int AW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    logic                 rst, start, cfg_we, grad_valid;
    logic [1:0]           cfg_sel;
    logic [AW-1:0]        cfg_addr;
    logic signed [11:0]   cfg_data, lipschitz, grad_data;
    logic                 busy, res_valid, grad_load_req, y_valid, done;
    logic [AW-1:0]        res_idx, y_idx;
    logic signed [11:0]   res_data, y_data;

    fg_update_engine #(.N(N), .ITERS(IT)) i_fg_update_engine (
        .clk(clk), .rst(rst), .start(start), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .lipschitz(lipschitz),
        .busy(busy), .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
        .grad_load_req(grad_load_req), .grad_valid(grad_valid), .grad_data(grad_data),
        .y_valid(y_valid), .y_idx(y_idx), .y_data(y_data), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int seed = 12345;

    int mx[N], mlo[N], mhi[N], mdl[IT], mg[N], mc[N], my[N];
    int eyn[N], ecn[N], eres[N];

    function automatic int sat(input int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int qmul(input int a, input int b);
        int p;
        p = a * b;
        return sat(p >>> 8);
    endfunction

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 1103515245 + 12345;
        return lo + (((seed >> 16) & 32'h7fff) % (hi - lo + 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cfg_write(input int sel, input int addr, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 2'(sel);
        cfg_addr = AW'(addr);
        cfg_data = 12'(data);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < N; i++) begin
            cfg_write(0, i, mx[i]);
            cfg_write(1, i, mlo[i]);
            cfg_write(2, i, mhi[i]);
        end
        for (int k = 0; k < IT; k++) cfg_write(3, k, mdl[k]);
    endtask

    // expected element results for iteration k from the requirement formulas
    task automatic model_pass(input int k);
        int t;
        for (int i = 0; i < N; i++) begin
            t = sat(mc[i] - qmul(mg[i], int'(lipschitz)));
            if (t > mhi[i])      eyn[i] = mhi[i];
            else if (t < mlo[i]) eyn[i] = mlo[i];
            else                 eyn[i] = t;
            ecn[i]  = sat(eyn[i] + qmul(mdl[k], sat(eyn[i] - my[i])));
            eres[i] = sat(ecn[i] - mx[i]);
        end
    endtask

    task automatic run_solve(input bit extreme, input bit gaps, input bit poke);
        int s_cyc, g_cyc, last_cyc, got, first_exp;
        int ng[N];
        string tag;
        @(negedge clk);
        start = 1'b1;
        s_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        g_cyc = 0;
        for (int i = 0; i < N; i++) begin
            mg[i] = 0;
            mc[i] = mx[i];
            my[i] = mx[i];
        end
        for (int k = 0; k < IT; k++) begin
            model_pass(k);
            if (extreme)     tag = "R1";
            else if (k == 0) tag = "R2";
            else             tag = "R3 R5";
            first_exp = (k == 0) ? (s_cyc + N + 8) : (g_cyc + 8);
            got = 0;
            last_cyc = 0;
            while (got < N) begin
                @(negedge clk);
                grad_valid = 1'b0;
                if (grad_load_req) chk(1'b0, "R7", 1, 0);
                if (res_valid) begin
                    if (got == 0)
                        chk(cyc == first_exp, (k == 0) ? "R10" : "R7", cyc, first_exp);
                    chk(int'(res_idx) == got, "R6", int'(res_idx), got);
                    chk(int'(res_data) == eres[got], tag, int'(res_data), eres[got]);
                    if (poke && k == 0 && got == 0) begin
                        chk(busy == 1'b1, "R9", int'(busy), 1);
                        cfg_we   = 1'b1;
                        cfg_sel  = 2'd2;
                        cfg_addr = '0;
                        cfg_data = -12'sd2048;
                        start    = 1'b1;
                    end else begin
                        cfg_we = 1'b0;
                        start  = 1'b0;
                    end
                    got++;
                    last_cyc = cyc;
                end
            end
            @(negedge clk);
            cfg_we = 1'b0;
            start  = 1'b0;
            chk(grad_load_req == 1'b1 && cyc == last_cyc + 1, "R7", int'(grad_load_req), 1);
            for (int i = 0; i < N; i++) ng[i] = extreme ? ((i % 2 == 0) ? 2047 : -2048)
                                                        : rnd(-800, 800);
            for (int i = 0; i < N; i++) begin
                if (gaps && (i % 3 == 1)) begin
                    grad_valid = 1'b0;
                    @(negedge clk);
                    chk(grad_load_req == 1'b1, "R7", int'(grad_load_req), 1);
                end
                grad_valid = 1'b1;
                grad_data  = 12'(ng[i]);
                g_cyc = cyc;
                @(negedge clk);
            end
            grad_valid = 1'b0;
            chk(grad_load_req == 1'b0, "R7", int'(grad_load_req), 0);
            if (gaps) begin
                // stray strobe with no request pending must be ignored
                grad_valid = 1'b1;
                grad_data  = 12'sd1000;
            end
            for (int i = 0; i < N; i++) begin
                mg[i] = ng[i];
                mc[i] = ecn[i];
                my[i] = eyn[i];
            end
        end
        got = 0;
        while (got < N) begin
            @(negedge clk);
            grad_valid = 1'b0;
            if (y_valid) begin
                if (got == 0) chk(cyc == g_cyc + 2, "R8", cyc, g_cyc + 2);
                chk(int'(y_idx) == got, "R8", int'(y_idx), got);
                chk(int'(y_data) == my[got], extreme ? "R1 R4" : "R4 R8", int'(y_data), my[got]);
                chk(done == (got == N - 1), "R8", int'(done), int'(got == N - 1));
                got++;
            end
        end
        @(negedge clk);
        chk(!busy && !y_valid, "R8", int'(busy), 0);
    endtask

    initial begin
        rst = 1'b1;
        start = 1'b0;
        cfg_we = 1'b0;
        cfg_sel = '0;
        cfg_addr = '0;
        cfg_data = '0;
        lipschitz = '0;
        grad_valid = 1'b0;
        grad_data = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !res_valid && !grad_load_req && !y_valid && !done, "R11",
            int'({busy, res_valid, grad_load_req, y_valid, done}), 0);

        // moderate random data, contiguous gradient words, busy-time pokes (R9)
        for (int i = 0; i < N; i++) begin
            mx[i]  = rnd(-1000, 1000);
            mlo[i] = rnd(-1500, 0);
            mhi[i] = mlo[i] + rnd(0, 1500);
        end
        for (int k = 0; k < IT; k++) mdl[k] = rnd(-128, 255);
        lipschitz = 12'(rnd(16, 512));
        load_all();
        run_solve(1'b0, 1'b0, 1'b1);

        // saturation corners and inverted boxes (lower above upper)
        for (int i = 0; i < N; i++) begin
            mx[i]  = (i % 2 == 0) ? 2047 : -2048;
            mlo[i] = (i % 4 < 2) ? -2048 : 500;
            mhi[i] = (i % 4 < 2) ? 2047 : -500;
        end
        mdl[0] = 2047;
        mdl[1] = -2048;
        mdl[2] = 1024;
        lipschitz = 12'sd2047;
        load_all();
        run_solve(1'b1, 1'b1, 1'b0);

        // fresh random data with gaps in the gradient stream, second restart
        for (int i = 0; i < N; i++) begin
            mx[i]  = rnd(-1800, 1800);
            mlo[i] = rnd(-2000, 200);
            mhi[i] = mlo[i] + rnd(0, 1800);
        end
        for (int k = 0; k < IT; k++) mdl[k] = rnd(-300, 300);
        lipschitz = 12'(rnd(200, 900));
        load_all();
        run_solve(1'b0, 1'b1, 1'b0);

        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule